// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between the write strobes of a parallel NOR-style flash bus and a small behavioural storage array. Each write cycle carries an address and a 16-bit data word, and the low byte of that data is decoded as a command. The block keeps a read mode and moves through the multi-cycle setups for single program, buffered program, block erase and lock control. Reads are combinational from the array, the identifier words, a query stub or the status word.

Programming and erase are timed by an internal countdown. A program clears bits and never sets them: the stored word becomes the old word AND the new data. An erase sets every word of a block to FFFFh. A buffered program takes a count n and then exactly n+1 data cycles. It is started only by a final D0h, and any other command in that position aborts it. Each block has a lock bit that refuses program and erase, and one command clears every lock bit together.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array (rd_mode 0). Every array word reads FFFFh, rd_oe is FFFFh, no block is locked and the engine is idle.
- R2: The low data byte selects the read mode: FFh array (0), 90h identifier (1), 98h query (2), 70h status (3). Bits 15:8 of a command write are ignored. In query mode offset 0 reads 0051h and offset 1 reads the words per block.
- R3: 40h or 10h followed by one write programs that write's address. The stored word becomes the old value AND the data.
- R4: E8h, then a count n, then n+1 data writes, then D0h programs every buffered word at its own address.
- R5: The count is accepted up to 000Fh in word mode (all 16 bits are compared) and up to 1Fh in byte mode. A larger count sets status bit 3, ends the sequence and programs nothing.
- R6: Any write other than D0h after the last data cycle aborts the buffered program, sets status bit 3 and leaves the array unchanged.
- R7: 20h followed by D0h erases the block of the second cycle's address to FFFFh. Any other second cycle sets status bit 3 and erases nothing.
- R8: 60h followed by 01h locks the addressed block. A program to a locked block sets status bits 4 and 1, an erase sets bits 5 and 1, and the array is not changed. A buffered program fails if any of its words falls in a locked block.
- R9: 60h followed by D0h clears every lock bit in the same cycle.
- R10: The status word is {8'h00, ready, 0, erase fail, program fail, sequence error, suspended, lock violation, 0}. While the engine runs in status mode, rd_oe is 0080h and bit 7 reads 0. Otherwise bit 7 reads 1.
- R11: B0h during a program (single or buffered) suspends it. The countdown freezes, status bits 7 and 2 read 1, the array is untouched, FFh and 70h change the mode, and D0h resumes. B0h during an erase is ignored.
- R12: 50h in idle clears status bits 5, 4, 3 and 1.
- R13: In identifier mode, offset 0 within a block reads 00A5h, offset 1 reads 5C3Eh, and offset 2 reads that block's lock bit.
- R14: In byte mode, address bit 0 selects the byte lane (1 = upper) of word address[6:1]. A programmed byte leaves the other lane unchanged, an array read returns the selected byte in bits 7:0, and rd_oe is 00FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects 8-bit bus addressing and byte counts |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 7 | Write address (word or byte) |
| wr_data | input | 16 | Write data or command |
| rd_addr | input | 7 | Read address |
| rd_data | output | 16 | Read data for the current mode |
| rd_oe | output | 16 | Per-bit valid mask of rd_data |
| rd_mode | output | 2 | Current read mode |
| eng_busy | output | 1 | Program/erase engine running or suspended |

## Verification
The hardest state to reach is a program that is suspended while its countdown is only partly done. The B0h write has to land on the cycle right after the starting write. The bench then reads status and the target word during the freeze, and only after that issues D0h. A full-length byte-mode buffered write also matters: 32 data cycles put two bytes into each word, so the word image shows whether the lanes merged or overwrote each other. Lock refusal is reached by locking a block, attempting each of the three operations on it, and only then clearing all locks at once.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int BLOCKS      = 4,
  parameter int BLOCK_WORDS = 16,
  parameter int PROG_CYC    = 8,
  parameter int ERASE_CYC   = 24,
  parameter logic [15:0] MFR_ID  = 16'h00A5,
  parameter logic [15:0] DEV_ID  = 16'h5C3E,
  parameter logic [15:0] QRY_TAG = 16'h0051,
  localparam int WORDS = BLOCKS * BLOCK_WORDS,
  localparam int WA    = $clog2(WORDS),
  localparam int OA    = $clog2(BLOCK_WORDS),
  localparam int WB    = 2 * BLOCK_WORDS,
  localparam int CW    = $clog2(WB),
  localparam int TMAX  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int TW    = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          wr_en,
  input  logic [WA:0]   wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [WA:0]   rd_addr,
  output logic [15:0]   rd_data,
  output logic [15:0]   rd_oe,
  output logic [1:0]    rd_mode,
  output logic          eng_busy
);
  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_QRY = 2'd2, M_ST = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_PRG, S_CNT, S_DAT, S_CNF, S_ERS, S_LCK} st_t;

  st_t              st;
  logic [15:0]      mem [WORDS];
  logic [WA-1:0]    ent_a [WB];
  logic [15:0]      ent_d [WB];
  logic [BLOCKS-1:0] lock;
  logic [CW-1:0]    n_cnt, idx, dix;
  logic [TW-1:0]    tmr;
  logic             busy, susp, op_erase;
  logic [WA-OA-1:0] ers_blk;
  logic             f_efail, f_pfail, f_seq, f_lock;
  logic             buf_locked;

  wire [7:0]      cmd   = wr_data[7:0];
  wire [WA-1:0]   w_idx = byte_mode ? wr_addr[WA:1] : wr_addr[WA-1:0];
  wire [WA-OA-1:0] w_blk = w_idx[WA-1:OA];
  wire [15:0]     w_val = !byte_mode ? wr_data :
                          wr_addr[0] ? {wr_data[7:0], 8'hFF} : {8'hFF, wr_data[7:0]};
  wire [15:0]     cnt_val = byte_mode ? {8'h00, wr_data[7:0]} : wr_data;
  wire            cnt_ok  = cnt_val <= (byte_mode ? 16'(WB - 1) : 16'(BLOCK_WORDS - 1));
  wire            run     = busy && !susp && tmr == '0;
  wire            do_erase = run && op_erase;
  wire            do_prog  = run && !op_erase;
  wire            ent_we   = wr_en && (st == S_PRG || st == S_DAT);
  wire [CW-1:0]   ent_i    = (st == S_DAT) ? idx : '0;

  always_comb begin
    buf_locked = 1'b0;
    for (int i = 0; i < WB; i++)
      if (CW'(i) <= n_cnt && lock[ent_a[i][WA-1:OA]]) buf_locked = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ent_we) begin
      ent_a[ent_i] <= w_idx;
      ent_d[ent_i] <= w_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else if (do_erase) begin
      for (int w = 0; w < WORDS; w++)
        if (w / BLOCK_WORDS == int'(ers_blk)) mem[w] <= '1;
    end else if (do_prog) begin
      mem[ent_a[dix]] <= mem[ent_a[dix]] & ent_d[dix];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  rd_mode <= M_ARR;  lock <= '0;
      n_cnt <= '0;  idx <= '0;  dix <= '0;  tmr <= '0;
      busy <= 1'b0;  susp <= 1'b0;  op_erase <= 1'b0;  ers_blk <= '0;
      f_efail <= 1'b0;  f_pfail <= 1'b0;  f_seq <= 1'b0;  f_lock <= 1'b0;
    end else begin
      if (busy && !susp) begin
        if (tmr != '0) tmr <= tmr - 1'b1;
        else if (op_erase || dix == n_cnt) busy <= 1'b0;
        else dix <= dix + 1'b1;
      end
      if (wr_en) begin
        if (busy && !susp) begin
          if (cmd == 8'hB0 && !op_erase) susp <= 1'b1;
          else if (cmd == 8'h70) rd_mode <= M_ST;
        end else if (busy) begin
          case (cmd)
            8'hFF: rd_mode <= M_ARR;
            8'h70: rd_mode <= M_ST;
            8'hD0: begin susp <= 1'b0; rd_mode <= M_ST; end
            default: ;
          endcase
        end else begin
          st <= S_IDLE;
          case (st)
            S_IDLE: case (cmd)
              8'hFF: rd_mode <= M_ARR;
              8'h90: rd_mode <= M_ID;
              8'h98: rd_mode <= M_QRY;
              8'h70: rd_mode <= M_ST;
              8'h50: begin f_efail <= 1'b0; f_pfail <= 1'b0; f_seq <= 1'b0; f_lock <= 1'b0; end
              8'h40, 8'h10: begin st <= S_PRG; rd_mode <= M_ST; end
              8'hE8: begin st <= S_CNT; rd_mode <= M_ST; end
              8'h20: begin st <= S_ERS; rd_mode <= M_ST; end
              8'h60: begin st <= S_LCK; rd_mode <= M_ST; end
              default: ;
            endcase
            S_PRG: begin
              n_cnt <= '0;
              if (lock[w_blk]) begin f_pfail <= 1'b1; f_lock <= 1'b1; end
              else begin busy <= 1'b1; op_erase <= 1'b0; dix <= '0; tmr <= TW'(PROG_CYC - 1); end
            end
            S_CNT: begin
              if (cnt_ok) begin n_cnt <= cnt_val[CW-1:0]; idx <= '0; st <= S_DAT; end
              else f_seq <= 1'b1;
            end
            S_DAT: begin
              if (idx == n_cnt) st <= S_CNF;
              else begin idx <= idx + 1'b1; st <= S_DAT; end
            end
            S_CNF: begin
              if (cmd != 8'hD0) f_seq <= 1'b1;
              else if (buf_locked) begin f_pfail <= 1'b1; f_lock <= 1'b1; end
              else begin busy <= 1'b1; op_erase <= 1'b0; dix <= '0; tmr <= TW'(PROG_CYC - 1); end
            end
            S_ERS: begin
              if (cmd != 8'hD0) f_seq <= 1'b1;
              else if (lock[w_blk]) begin f_efail <= 1'b1; f_lock <= 1'b1; end
              else begin busy <= 1'b1; op_erase <= 1'b1; ers_blk <= w_blk; tmr <= TW'(ERASE_CYC - 1); end
            end
            S_LCK: begin
              if (cmd == 8'h01) lock[w_blk] <= 1'b1;
              else if (cmd == 8'hD0) lock <= '0;
              else f_seq <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  wire [WA-1:0]    r_idx  = byte_mode ? rd_addr[WA:1] : rd_addr[WA-1:0];
  wire [15:0]      r_word = mem[r_idx];
  wire [OA-1:0]    r_off  = r_idx[OA-1:0];
  wire [WA-OA-1:0] r_blk  = r_idx[WA-1:OA];
  wire [7:0]       sr     = {!busy || susp, 1'b0, f_efail, f_pfail, f_seq, susp, f_lock, 1'b0};

  always_comb begin
    case (rd_mode)
      M_ARR:   rd_data = !byte_mode ? r_word :
                         {8'h00, rd_addr[0] ? r_word[15:8] : r_word[7:0]};
      M_ID:    rd_data = (r_off == OA'(0)) ? MFR_ID :
                         (r_off == OA'(1)) ? DEV_ID :
                         (r_off == OA'(2)) ? {15'h0, lock[r_blk]} : 16'h0;
      M_QRY:   rd_data = (r_off == OA'(0)) ? QRY_TAG :
                         (r_off == OA'(1)) ? 16'(BLOCK_WORDS) : 16'h0;
      default: rd_data = {8'h00, sr};
    endcase
  end

  assign rd_oe    = (rd_mode == M_ST && busy && !susp) ? 16'h0080 :
                    byte_mode ? 16'h00FF : 16'hFFFF;
  assign eng_busy = busy;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int BLOCKS = 4,
  parameter int TW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [15:0]       wr_data,
  input logic [15:0]       rd_data,
  input logic [15:0]       rd_oe,
  input logic [1:0]        rd_mode,
  input logic              eng_busy,
  input logic              susp,
  input logic              op_erase,
  input logic              f_seq,
  input logic [TW-1:0]     tmr,
  input logic [BLOCKS-1:0] lock,
  input logic [2:0]        st
);
  localparam logic [2:0] C_IDLE = 3'd0, C_CNF = 3'd4, C_LCK = 3'd6;

  AST_ERASE_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eng_busy) && op_erase) |-> $past(wr_en && wr_data[7:0] == 8'hD0)); // R7

  AST_ABORT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_CNF && wr_en && wr_data[7:0] != 8'hD0) |=> (!eng_busy && f_seq)); // R6

  AST_LOCKS_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_LCK && wr_en && wr_data[7:0] == 8'hD0) |=> (lock == '0)); // R9

  AST_BUSY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !susp && rd_mode == 2'd3) |-> (rd_oe == 16'h0080 && !rd_data[7])); // R10

  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && $past(susp)) |-> (tmr == $past(tmr))); // R11

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && !eng_busy && wr_en && wr_data[7:0] == 8'h50) |=> !f_seq); // R12
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.BLOCKS(BLOCKS), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .rd_oe(rd_oe), .rd_mode(rd_mode), .eng_busy(eng_busy),
  .susp(susp), .op_erase(op_erase), .f_seq(f_seq), .tmr(tmr), .lock(lock), .st(st)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_W = 2'd0, K_C = 2'd1, K_T = 2'd2;
  localparam int NV = 112;

  // {kind, req, addr, data, expected}
  localparam logic [44:0] VEC [NV] = '{
    {K_W,4'd2,7'h00,16'h00FF,16'h0}, {K_C,4'd1,7'h05,16'h0,16'hFFFF},             // R1 erased array
    {K_W,4'd3,7'h05,16'h0040,16'h0}, {K_W,4'd3,7'h05,16'h1234,16'h0},             // R3 program via 40h
    {K_T,4'd3,7'h00,16'd20,16'h0},   {K_W,4'd2,7'h00,16'h00FF,16'h0},
    {K_C,4'd3,7'h05,16'h0,16'h1234},
    {K_W,4'd3,7'h06,16'h0010,16'h0}, {K_W,4'd3,7'h06,16'h00F0,16'h0},             // R3 program via 10h
    {K_T,4'd3,7'h00,16'd20,16'h0},   {K_W,4'd2,7'h00,16'h00FF,16'h0},
    {K_C,4'd3,7'h06,16'h0,16'h00F0},
    {K_W,4'd3,7'h05,16'h0040,16'h0}, {K_W,4'd3,7'h05,16'hFF0F,16'h0},             // R3 AND with old value
    {K_T,4'd3,7'h00,16'd20,16'h0},   {K_W,4'd2,7'h00,16'h00FF,16'h0},
    {K_C,4'd3,7'h05,16'h0,16'h1204},
    {K_W,4'd4,7'h10,16'h00E8,16'h0}, {K_W,4'd4,7'h10,16'h0002,16'h0},             // R4 buffered, n=2
    {K_W,4'd4,7'h10,16'hAAAA,16'h0}, {K_W,4'd4,7'h11,16'h5555,16'h0},
    {K_W,4'd4,7'h12,16'h0F0F,16'h0}, {K_W,4'd4,7'h10,16'h00D0,16'h0},
    {K_T,4'd4,7'h00,16'd40,16'h0},   {K_W,4'd2,7'h00,16'h00FF,16'h0},
    {K_C,4'd4,7'h10,16'h0,16'hAAAA}, {K_C,4'd4,7'h11,16'h0,16'h5555},
    {K_C,4'd4,7'h12,16'h0,16'h0F0F}, {K_C,4'd4,7'h13,16'h0,16'hFFFF},
    {K_W,4'd6,7'h20,16'h00E8,16'h0}, {K_W,4'd6,7'h20,16'h0001,16'h0},             // R6 abort
    {K_W,4'd6,7'h20,16'h1111,16'h0}, {K_W,4'd6,7'h21,16'h2222,16'h0},
    {K_W,4'd6,7'h20,16'h00FF,16'h0}, {K_W,4'd6,7'h00,16'h0070,16'h0},
    {K_C,4'd6,7'h00,16'h0,16'h0088}, {K_W,4'd2,7'h00,16'h00FF,16'h0},
    {K_C,4'd6,7'h20,16'h0,16'hFFFF}, {K_C,4'd6,7'h21,16'h0,16'hFFFF},
    {K_W,4'd12,7'h00,16'h0050,16'h0},{K_W,4'd12,7'h00,16'h0070,16'h0},            // R12 clear status
    {K_C,4'd12,7'h00,16'h0,16'h0080},
    {K_W,4'd5,7'h30,16'h00E8,16'h0}, {K_W,4'd5,7'h30,16'h0010,16'h0},             // R5 count too big
    {K_C,4'd5,7'h00,16'h0,16'h0088}, {K_W,4'd12,7'h00,16'h0050,16'h0},
    {K_W,4'd5,7'h30,16'h00E8,16'h0}, {K_W,4'd5,7'h30,16'h0100,16'h0},             // R5 upper count byte counts
    {K_C,4'd5,7'h00,16'h0,16'h0088}, {K_W,4'd12,7'h00,16'h0050,16'h0},
    {K_W,4'd7,7'h15,16'h0020,16'h0}, {K_W,4'd7,7'h15,16'h00D0,16'h0},             // R7 block erase
    {K_T,4'd7,7'h00,16'd40,16'h0},   {K_W,4'd2,7'h00,16'h00FF,16'h0},
    {K_C,4'd7,7'h10,16'h0,16'hFFFF}, {K_C,4'd7,7'h12,16'h0,16'hFFFF},
    {K_C,4'd7,7'h1F,16'h0,16'hFFFF}, {K_C,4'd7,7'h05,16'h0,16'h1204},
    {K_W,4'd3,7'h18,16'h0040,16'h0}, {K_W,4'd3,7'h18,16'h00FF,16'h0},
    {K_T,4'd3,7'h00,16'd20,16'h0},
    {K_W,4'd7,7'h18,16'h0020,16'h0}, {K_W,4'd7,7'h18,16'h00FF,16'h0},             // R7 bad confirm
    {K_W,4'd7,7'h00,16'h0070,16'h0}, {K_C,4'd7,7'h00,16'h0,16'h0088},
    {K_W,4'd2,7'h00,16'h00FF,16'h0}, {K_C,4'd7,7'h18,16'h0,16'h00FF},
    {K_W,4'd12,7'h00,16'h0050,16'h0},
    {K_W,4'd8,7'h20,16'h0060,16'h0}, {K_W,4'd8,7'h20,16'h0001,16'h0},             // R8 lock block 2
    {K_W,4'd13,7'h00,16'h0090,16'h0},{K_C,4'd13,7'h00,16'h0,16'h00A5},            // R13 identifier
    {K_C,4'd13,7'h01,16'h0,16'h5C3E},{K_C,4'd13,7'h22,16'h0,16'h0001},
    {K_C,4'd13,7'h02,16'h0,16'h0000},
    {K_W,4'd8,7'h21,16'h0040,16'h0}, {K_W,4'd8,7'h21,16'h0000,16'h0},             // R8 program refused
    {K_W,4'd8,7'h00,16'h0070,16'h0}, {K_C,4'd8,7'h00,16'h0,16'h0092},
    {K_W,4'd2,7'h00,16'h00FF,16'h0}, {K_C,4'd8,7'h21,16'h0,16'hFFFF},
    {K_W,4'd12,7'h00,16'h0050,16'h0},
    {K_W,4'd8,7'h05,16'h0060,16'h0}, {K_W,4'd8,7'h05,16'h0001,16'h0},             // R8 erase refused
    {K_W,4'd8,7'h05,16'h0020,16'h0}, {K_W,4'd8,7'h05,16'h00D0,16'h0},
    {K_C,4'd8,7'h00,16'h0,16'h00A2}, {K_W,4'd2,7'h00,16'h00FF,16'h0},
    {K_C,4'd8,7'h05,16'h0,16'h1204}, {K_W,4'd12,7'h00,16'h0050,16'h0},
    {K_W,4'd8,7'h22,16'h00E8,16'h0}, {K_W,4'd8,7'h22,16'h0000,16'h0},             // R8 buffered refused
    {K_W,4'd8,7'h22,16'h0000,16'h0}, {K_W,4'd8,7'h22,16'h00D0,16'h0},
    {K_C,4'd8,7'h00,16'h0,16'h0092}, {K_W,4'd12,7'h00,16'h0050,16'h0},
    {K_W,4'd9,7'h00,16'h0060,16'h0}, {K_W,4'd9,7'h00,16'h00D0,16'h0},             // R9 clear all locks
    {K_W,4'd9,7'h00,16'h0090,16'h0}, {K_C,4'd9,7'h02,16'h0,16'h0000},
    {K_C,4'd9,7'h22,16'h0,16'h0000},
    {K_W,4'd9,7'h21,16'h0040,16'h0}, {K_W,4'd9,7'h21,16'h4321,16'h0},
    {K_T,4'd9,7'h00,16'd20,16'h0},
    {K_W,4'd2,7'h00,16'h12FF,16'h0}, {K_C,4'd9,7'h21,16'h0,16'h4321},             // R2 upper byte ignored
    {K_W,4'd2,7'h00,16'hAB70,16'h0}, {K_C,4'd2,7'h00,16'h0,16'h0080},
    {K_W,4'd2,7'h00,16'h0098,16'h0}, {K_C,4'd2,7'h00,16'h0,16'h0051},             // R2 query mode
    {K_C,4'd2,7'h01,16'h0,16'h0010}, {K_W,4'd2,7'h00,16'h00FF,16'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data, rd_oe;
  logic [1:0]  rd_mode;
  logic        eng_busy;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_oe(rd_oe), .rd_mode(rd_mode), .eng_busy(eng_busy)
  );

  task automatic chk(input int req, input logic [15:0] got, input logic [15:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int req, input logic [6:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp, $sformatf("read @%h", a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(1, 16'(rd_mode), 16'h0, "mode after reset");
    chk(1, rd_oe, 16'hFFFF, "oe after reset");
    chk(1, 16'(eng_busy), 16'h0, "busy after reset");
    rd(1, 7'h00, 16'hFFFF);
    rd(1, 7'h3F, 16'hFFFF);
    wr(7'h00, 16'h0070);
    chk(2, 16'(rd_mode), 16'h3, "status mode");
    rd(1, 7'h00, 16'h0080);
    wr(7'h00, 16'h0090);
    chk(2, 16'(rd_mode), 16'h1, "identifier mode");
    rd(1, 7'h12, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][44:43])
        K_W: wr(VEC[k][38:32], VEC[k][31:16]);
        K_C: rd(int'(VEC[k][42:39]), VEC[k][38:32], VEC[k][15:0]);
        default: idle(int'(VEC[k][31:16]));
      endcase
    end

    // R10 busy masking and ready bit
    wr(7'h30, 16'h0040);
    wr(7'h30, 16'h0F00);
    chk(10, 16'(eng_busy), 16'h1, "busy after start");
    chk(10, rd_oe, 16'h0080, "oe while busy");
    rd(10, 7'h00, 16'h0000);
    idle(20);
    chk(10, rd_oe, 16'hFFFF, "oe when ready");
    rd(10, 7'h00, 16'h0080);
    wr(7'h00, 16'h00FF);
    rd(3, 7'h30, 16'h0F00);

    // R11 suspend a program, resume it
    wr(7'h31, 16'h0040);
    wr(7'h31, 16'h00F0);
    wr(7'h00, 16'h00B0);
    idle(30);
    chk(11, 16'(eng_busy), 16'h1, "still pending while suspended");
    chk(11, rd_oe, 16'hFFFF, "oe while suspended");
    rd(11, 7'h00, 16'h0084);
    wr(7'h00, 16'h00FF);
    rd(11, 7'h31, 16'hFFFF);
    wr(7'h00, 16'h00D0);
    chk(11, 16'(rd_mode), 16'h3, "mode after resume");
    idle(20);
    chk(11, 16'(eng_busy), 16'h0, "done after resume");
    wr(7'h00, 16'h00FF);
    rd(11, 7'h31, 16'h00F0);

    // R11 suspend has no effect on erase
    wr(7'h30, 16'h0020);
    wr(7'h30, 16'h00D0);
    wr(7'h00, 16'h00B0);
    chk(11, rd_oe, 16'h0080, "erase keeps running");
    rd(11, 7'h00, 16'h0000);
    idle(40);
    wr(7'h00, 16'h00FF);
    rd(7, 7'h30, 16'hFFFF);
    rd(7, 7'h31, 16'hFFFF);

    // R14 / R5 byte mode: full 32-byte buffer into block 3
    byte_mode = 1'b1;
    wr(7'h60, 16'h00E8);
    wr(7'h60, 16'h001F);
    for (int i = 0; i < 32; i++) wr(7'(7'h60 + i), 16'(i));
    wr(7'h60, 16'h00D0);
    idle(60);
    wr(7'h00, 16'h00FF);
    chk(14, rd_oe, 16'h00FF, "byte mode oe");
    rd(14, 7'h61, 16'h0001);
    rd(14, 7'h7F, 16'h001F);
    byte_mode = 1'b0;
    rd(14, 7'h30, 16'h0100);
    rd(5, 7'h3F, 16'h1F1E);

    byte_mode = 1'b1;
    wr(7'h00, 16'h00E8);
    wr(7'h00, 16'h0020);
    rd(5, 7'h00, 16'h0088);
    wr(7'h00, 16'h0050);

    // R14 single byte program leaves the other lane
    wr(7'h01, 16'h0040);
    wr(7'h01, 16'h003C);
    idle(20);
    wr(7'h00, 16'h00FF);
    rd(14, 7'h01, 16'h003C);
    rd(14, 7'h00, 16'h00FF);
    byte_mode = 1'b0;
    rd(14, 7'h00, 16'h3CFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule